// File: doc/BRIEF.md
# Supply Detector Enable and Mask Synchronizer

This block sits between a fast register clock domain and a slow, always-on oscillator domain. It controls a power-on-reset style supply detector. Software writes two control bits, a detector enable and a reset mask. These bits cross into the slow domain through a toggle handshake. The slow domain holds the effective enable and mask. Those effective bits are synchronized back to the register domain as read-only status, so software always sees the real state, which lags behind what it wrote.

The analog comparator is modelled as a digital input, `det_raw`, which lives in the slow domain. When the effective enable is set and the effective mask is clear, a comparator hit becomes a stretched system reset request. An update that would switch the detector off can only complete while the oscillator-enable input is high; until then it waits. Software is expected to make masking effective before it changes the enable, so that the transition cannot cause a spurious reset.

Top module: `supdet_ctl`

## Requirements
- R1: While reset is held and just after it is released, `stat_enable` is 1, `stat_mask` is 0 and `sys_rst_req` is 0.
- R2: Writing enable 0 while the oscillator runs makes `stat_enable` read 0 within 80 register cycles. Writing enable 1 afterwards makes it read 1 again.
- R3: Two register cycles after a write, the status outputs still show the previous effective values.
- R4: Writing mask 1 makes `stat_mask` read 1 only after synchronization, within 80 register cycles. Writing mask 0 returns it to 0.
- R5: A write that clears enable, issued while `osc_en` is 0, is held as a whole: neither status bit changes. The write completes once `osc_en` returns to 1.
- R6: Once a disable has completed, dropping `osc_en` does not bring the enable back; `stat_enable` stays 0.
- R7: While the effective enable is 1 and the effective mask is 0, a high `det_raw` drives `sys_rst_req` to 1 at the next slow clock edge.
- R8: While the effective mask is 1, `det_raw` has no effect on `sys_rst_req`.
- R9: While the effective enable is 0, `det_raw` has no effect on `sys_rst_req`.
- R10: A hit lasting L slow cycles holds `sys_rst_req` high for exactly L+1 slow cycles, so it is never shorter than 2.
- R11: Writes issued back to back, before earlier ones have crossed, are not lost. The last written pair always becomes effective.
- R12: A write that leaves enable at 1 completes even while `osc_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_reg | input | 1 | Fast register-domain clock |
| clk_slow | input | 1 | Slow always-on oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_stb | input | 1 | One-cycle write strobe (register domain) |
| wr_en_bit | input | 1 | Written detector enable value |
| wr_mask_bit | input | 1 | Written reset mask value |
| osc_en | input | 1 | Slow oscillator running; required for a disable to complete (slow domain) |
| det_raw | input | 1 | Digital model of the comparator output (slow domain) |
| stat_enable | output | 1 | Effective detector enable, synchronized to the register domain |
| stat_mask | output | 1 | Effective mask, synchronized to the register domain |
| sys_rst_req | output | 1 | Stretched system reset request (slow domain) |

## Verification
Several internal faults can each be seen at the ports:

- **Stuck handshake or lost toggle.** The status pair never reaches the last written values, or it settles on an older pair. This shows within a few tens of register cycles after the write.
- **Stall applied to the wrong kind of update.** Either the status moves while `osc_en` is low, or it stays frozen after `osc_en` returns.
- **Wrong gate or stretch counter.** The number of slow cycles during which `sys_rst_req` is high differs from L+1, or is non-zero under mask or disable. This is visible within one or two slow cycles of the hit.

// File: rtl/supdet_pkg.sv
package supdet_pkg;

  // Reset request gate: the comparator hit passes only if the detector is
  // effectively enabled and not effectively masked.
  function automatic logic rst_gate(input logic raw, input logic en, input logic mask);
    return raw & en & ~mask;
  endfunction

  // A pending update may be applied unless it switches the detector off
  // while the slow oscillator is stopped.
  function automatic logic apply_ok(input logic new_en, input logic osc_on);
    return new_en | osc_on;
  endfunction

endpackage

// File: rtl/supdet_sync.sv
module supdet_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/supdet_fast_req.sv
module supdet_fast_req (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic wr_en_bit,
  input  logic wr_mask_bit,
  input  logic ack_tgl_s,
  output logic req_tgl,
  output logic req_en,
  output logic req_mask
);
  logic dirty_q;
  logic pend_w;
  logic issue_w;

  assign pend_w  = req_tgl ^ ack_tgl_s;
  assign issue_w = dirty_q & ~pend_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_en   <= 1'b1;
      req_mask <= 1'b0;
      dirty_q  <= 1'b0;
      req_tgl  <= 1'b0;
    end else begin
      if (wr_stb) begin
        req_en   <= wr_en_bit;
        req_mask <= wr_mask_bit;
        dirty_q  <= 1'b1;
      end else if (issue_w) begin
        dirty_q  <= 1'b0;
      end
      if (issue_w) req_tgl <= ~req_tgl;
    end
  end

  // R11
  no_double_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_w |=> $stable(req_tgl));

  // R11
  write_marks_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> dirty_q);
endmodule

// File: rtl/supdet_stretch.sv
module supdet_stretch #(
  parameter int MIN_PULSE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic pulse_q
);
  localparam int CNT_W = $clog2(MIN_PULSE + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (hit) begin
      cnt_q   <= CNT_W'(MIN_PULSE - 1);
      pulse_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q   <= cnt_q - 1'b1;
    end else begin
      pulse_q <= 1'b0;
    end
  end

  // R7
  rise_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> $past(hit));

  // R10
  min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pulse_q) && (MIN_PULSE > 1)) |=> pulse_q);
endmodule

// File: rtl/supdet_slow_core.sv
module supdet_slow_core
  import supdet_pkg::*;
#(
  parameter int MIN_PULSE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic req_tgl_s,
  input  logic req_en_s,
  input  logic req_mask_s,
  input  logic det_raw,
  output logic ack_tgl,
  output logic eff_en,
  output logic eff_mask,
  output logic rst_out
);
  logic pend_w;
  logic apply_w;
  logic hit_w;

  assign pend_w  = req_tgl_s ^ ack_tgl;
  assign apply_w = pend_w & apply_ok(req_en_s, osc_en);
  assign hit_w   = rst_gate(det_raw, eff_en, eff_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_tgl  <= 1'b0;
      eff_en   <= 1'b1;
      eff_mask <= 1'b0;
    end else if (apply_w) begin
      ack_tgl  <= req_tgl_s;
      eff_en   <= req_en_s;
      eff_mask <= req_mask_s;
    end
  end

  supdet_stretch #(.MIN_PULSE(MIN_PULSE)) stretch_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit_w),
    .pulse_q (rst_out)
  );

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_w && !osc_en && !req_en_s) |=> ($stable(eff_en) && $stable(eff_mask)));

  // R5
  off_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eff_en) |-> $past(osc_en));

  // R8
  mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mask && !rst_out) |=> !rst_out);

  // R9
  off_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eff_en && !rst_out) |=> !rst_out);
endmodule

// File: rtl/supdet_ctl.sv
module supdet_ctl #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 2
) (
  input  logic clk_reg,
  input  logic clk_slow,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic wr_en_bit,
  input  logic wr_mask_bit,
  input  logic osc_en,
  input  logic det_raw,
  output logic stat_enable,
  output logic stat_mask,
  output logic sys_rst_req
);
  localparam int          XW     = 3;
  localparam logic [XW-1:0] XRST = 3'b010;

  logic req_tgl, req_en, req_mask;
  logic req_tgl_s, req_en_s, req_mask_s;
  logic ack_tgl, eff_en, eff_mask;
  logic ack_tgl_s;

  supdet_fast_req fast_i (
    .clk         (clk_reg),
    .rst_n       (rst_n),
    .wr_stb      (wr_stb),
    .wr_en_bit   (wr_en_bit),
    .wr_mask_bit (wr_mask_bit),
    .ack_tgl_s   (ack_tgl_s),
    .req_tgl     (req_tgl),
    .req_en      (req_en),
    .req_mask    (req_mask)
  );

  supdet_sync #(.W(XW), .STAGES(SYNC_STAGES), .RST_VAL(XRST)) to_slow_i (
    .clk   (clk_slow),
    .rst_n (rst_n),
    .d     ({req_tgl, req_en, req_mask}),
    .q     ({req_tgl_s, req_en_s, req_mask_s})
  );

  supdet_slow_core #(.MIN_PULSE(MIN_PULSE)) slow_i (
    .clk        (clk_slow),
    .rst_n      (rst_n),
    .osc_en     (osc_en),
    .req_tgl_s  (req_tgl_s),
    .req_en_s   (req_en_s),
    .req_mask_s (req_mask_s),
    .det_raw    (det_raw),
    .ack_tgl    (ack_tgl),
    .eff_en     (eff_en),
    .eff_mask   (eff_mask),
    .rst_out    (sys_rst_req)
  );

  supdet_sync #(.W(XW), .STAGES(SYNC_STAGES), .RST_VAL(XRST)) to_fast_i (
    .clk   (clk_reg),
    .rst_n (rst_n),
    .d     ({ack_tgl, eff_en, eff_mask}),
    .q     ({ack_tgl_s, stat_enable, stat_mask})
  );

  // R3
  stat_lags_write_chk: assert property (@(posedge clk_reg) disable iff (!rst_n)
    wr_stb |=> ($stable(stat_enable) && $stable(stat_mask)));
endmodule

// File: tb/supdet_ctl_tb_top.sv
module supdet_ctl_tb_top;
  logic clk_reg = 1'b0;
  logic clk_slow = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0, wr_en_bit = 1'b1, wr_mask_bit = 1'b0;
  logic osc_en = 1'b1, det_raw = 1'b0;
  logic stat_enable, stat_mask, sys_rst_req;

  always #5  clk_reg  = ~clk_reg;
  always #35 clk_slow = ~clk_slow;

  supdet_ctl dut_i (
    .clk_reg(clk_reg), .clk_slow(clk_slow), .rst_n(rst_n),
    .wr_stb(wr_stb), .wr_en_bit(wr_en_bit), .wr_mask_bit(wr_mask_bit),
    .osc_en(osc_en), .det_raw(det_raw),
    .stat_enable(stat_enable), .stat_mask(stat_mask), .sys_rst_req(sys_rst_req)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    logic  en;
    logic  mask;
    bit    hold;     // 0: must reach within cycles, 1: must stay for cycles
    int    cycles;
    string req;
  } item_t;

  item_t sb_q[$];
  bit    mon_busy = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected status pairs and compares them with the ports.
  initial begin
    forever begin
      wait (sb_q.size() > 0);
      mon_busy = 1;
      begin
        item_t it;
        bit ok;
        it = sb_q.pop_front();
        ok = it.hold;
        for (int c = 0; c < it.cycles; c++) begin
          @(negedge clk_reg);
          if (it.hold) begin
            if ({stat_enable, stat_mask} != {it.en, it.mask}) ok = 0;
          end else if ({stat_enable, stat_mask} == {it.en, it.mask}) begin
            ok = 1;
            break;
          end
        end
        check(ok, it.req, {stat_enable, stat_mask}, {it.en, it.mask});
      end
      mon_busy = 0;
    end
  end

  task automatic expect_state(input logic en, input logic mask, input bit hold,
                              input int cycles, input string req);
    item_t it;
    it.en = en; it.mask = mask; it.hold = hold; it.cycles = cycles; it.req = req;
    sb_q.push_back(it);
    #1;
    wait (sb_q.size() == 0 && !mon_busy);
  endtask

  task automatic wr(input logic en, input logic mask);
    @(negedge clk_reg);
    wr_stb = 1'b1; wr_en_bit = en; wr_mask_bit = mask;
    @(negedge clk_reg);
    wr_stb = 1'b0;
  endtask

  task automatic set_osc(input logic v);
    @(negedge clk_slow);
    osc_en = v;
  endtask

  // Hit of L slow cycles; returns number of slow cycles with sys_rst_req high.
  task automatic det_pulse(input int len, output int high_cnt);
    high_cnt = 0;
    @(negedge clk_slow);
    det_raw = 1'b1;
    for (int i = 1; i <= len + 6; i++) begin
      @(negedge clk_slow);
      if (sys_rst_req) high_cnt++;
      if (i == len) det_raw = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    check(0, "watchdog", 0, 1);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int cnt;
    #103;
    // R1: reset state while held
    check({stat_enable, stat_mask, sys_rst_req} == 3'b100, "R1 in reset",
          {stat_enable, stat_mask, sys_rst_req}, 3'b100);
    @(negedge clk_reg); rst_n = 1'b1;
    repeat (20) @(negedge clk_reg);
    check({stat_enable, stat_mask, sys_rst_req} == 3'b100, "R1 after reset",
          {stat_enable, stat_mask, sys_rst_req}, 3'b100);

    // R3, R4: mask on, lagging readback
    wr(1'b1, 1'b1);
    @(negedge clk_reg);
    check(stat_mask == 1'b0, "R3 mask lag", stat_mask, 0);
    expect_state(1'b1, 1'b1, 0, 80, "R4 mask set");

    // R2: disable with mask effective, then R9
    wr(1'b0, 1'b1);
    expect_state(1'b0, 1'b1, 0, 80, "R2 disable");
    wr(1'b0, 1'b0);
    expect_state(1'b0, 1'b0, 0, 80, "R4 mask clear");
    det_pulse(3, cnt);
    check(cnt == 0, "R9 disabled no reset", cnt, 0);
    wr(1'b0, 1'b1);
    expect_state(1'b0, 1'b1, 0, 80, "R4 mask set again");
    wr(1'b1, 1'b1);
    expect_state(1'b1, 1'b1, 0, 80, "R2 re-enable");

    // R8: masked, long hit
    det_pulse(5, cnt);
    check(cnt == 0, "R8 masked no reset", cnt, 0);

    // R5: disable stalls while oscillator off
    set_osc(1'b0);
    wr(1'b0, 1'b0);
    expect_state(1'b1, 1'b1, 1, 120, "R5 stalled");
    set_osc(1'b1);
    expect_state(1'b0, 1'b0, 0, 80, "R5 completes");

    // R6: oscillator off after disable completed
    set_osc(1'b0);
    expect_state(1'b0, 1'b0, 1, 120, "R6 stays off");

    // R12: enabling proceeds with oscillator off
    wr(1'b1, 1'b1);
    expect_state(1'b1, 1'b1, 0, 80, "R12 enable while osc off");
    set_osc(1'b1);
    wr(1'b1, 1'b0);
    expect_state(1'b1, 1'b0, 0, 80, "R4 unmask");

    // R7, R10: unmasked hits
    det_pulse(1, cnt);
    check(cnt == 2, "R7 R10 single-cycle hit", cnt, 2);
    det_pulse(4, cnt);
    check(cnt == 5, "R10 four-cycle hit", cnt, 5);

    // R11: back-to-back writes
    @(negedge clk_reg);
    wr_stb = 1'b1; wr_en_bit = 1'b1; wr_mask_bit = 1'b1;
    @(negedge clk_reg);
    wr_en_bit = 1'b0; wr_mask_bit = 1'b1;
    @(negedge clk_reg);
    wr_stb = 1'b0;
    expect_state(1'b0, 1'b1, 0, 80, "R11 last of two");
    expect_state(1'b0, 1'b1, 1, 60, "R11 stays");
    wr(1'b1, 1'b1);
    repeat (3) @(negedge clk_reg);
    wr(1'b1, 1'b0);
    expect_state(1'b1, 1'b0, 0, 120, "R11 mid-flight write");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule